// File: doc/BRIEF.md
# Dual-Port Sample Demultiplexer with Reset Phase Alignment

The block accepts one sample on every rising edge of the sample clock and splits the stream into pairs. The earlier sample of each pair goes to the auxiliary port and the later one to the primary port. A data-ready output runs at half the sample rate. It is high while one sample is held and waiting for its partner. It falls on the edge that writes a new pair to both ports.

A synchronous reset request puts the data-ready divider into a fixed reset phase, with data-ready held high. It also drives a reset output that downstream demultiplexers can use. If the divider is already in the right phase when the request takes effect, the pending sample is captured and the reset output follows the request. If the divider is in the wrong phase, one clock edge is swallowed instead. That edge captures nothing, and the reset output stays low for the whole episode.

After release, the first pair pairs the sample held from before the reset with the first sample that arrives after it. That sample is out of sequence. In the swallowed case it is the sample taken just before the swallowed edge.

Top module: `dual_port_demux`

## Requirements
- R1: While `rst_n` is low, `aux_out` and `pri_out` are 0 and `drdy` and `sync_out` are 0. After `rst_n` rises, the third rising edge is the first one to process a sample.
- R2: In normal operation samples are taken in pairs. The first sample of a pair is held and leaves both ports unchanged. The second sample is written to `pri_out` and the held sample to `aux_out`, both on the same edge.
- R3: In normal operation `drdy` changes level on every edge. It is 1 after the first sample of a pair has been taken and 0 after a pair has been written.
- R4: `sync_req` passes through two registers. The reset action first takes place on the third rising edge, counting from the first edge that samples `sync_req` high. The two edges before it still process samples normally.
- R5: Aligned case: `drdy` is 0 in the cycle before the first edge that samples `sync_req` high. The action edge then holds that cycle's sample and sets `drdy` to 1. `sync_out` is then 1 for as many cycles as `sync_req` was sampled high.
- R6: Misaligned case: `drdy` is 1 in that cycle. The action edge is then swallowed, with no capture, no port change and `drdy` staying at 1. `sync_out` stays 0 for the whole episode.
- R7: While the synchronized request is active, `drdy` stays 1, both ports keep their values and incoming samples are dropped.
- R8: On the first edge after the synchronized request falls, `aux_out` receives the sample held from before the reset and `pri_out` receives the sample of that cycle. On the same edge `drdy` and `sync_out` go to 0.
- R9: A `sync_req` that is high for a single clock is enough. In the aligned case it produces a `sync_out` pulse one cycle long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; every rising edge carries one sample |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously inside |
| smp_in | input | 8 | Incoming sample |
| sync_req | input | 1 | Synchronous request to realign the data-ready phase |
| aux_out | output | 8 | Older sample of the latest pair |
| pri_out | output | 8 | Newer sample of the latest pair |
| drdy | output | 1 | Half-rate data-ready clock; high while a sample waits for its partner |
| sync_out | output | 1 | Reset output for downstream demultiplexers |

## Verification
The assertions assume that `sync_req` changes only between rising edges, so that each edge sees one clean level. They also assume that `rst_n` is held low for long enough to clear both synchronizer chains. The bench drives every input on the falling edge and keeps `rst_n` low for several cycles. Before each request it reads `drdy` and inserts one extra sample when needed, so that the aligned and swallowed cases are each reached deliberately rather than by chance.

// File: rtl/dpd_pkg.sv
package dpd_pkg;
  // What the pair store does on a given edge
  typedef enum logic [1:0] {
    ACT_FREEZE = 2'd0,  // keep hold register and ports
    ACT_LOAD   = 2'd1,  // capture first sample of a pair
    ACT_EMIT   = 2'd2   // write held + current sample to ports
  } store_act_e;
endpackage

// File: rtl/dpd_rst_sync.sv
module dpd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_ok
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_ok = chain_q[LAST];
endmodule

// File: rtl/dpd_req_sync.sv
module dpd_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ok,
  input  logic req_in,
  output logic req_lvl,
  output logic req_first
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] stg_q;
  logic          lvl_prev_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_ok) begin
        if (!rst_ok) stg_q <= '0;
        else         stg_q <= req_in;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_ok) begin
        if (!rst_ok) stg_q <= '0;
        else         stg_q <= {stg_q[LAST-1:0], req_in};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) lvl_prev_q <= 1'b0;
    else         lvl_prev_q <= stg_q[LAST];
  end

  assign req_lvl   = stg_q[LAST];
  assign req_first = stg_q[LAST] & ~lvl_prev_q;
endmodule

// File: rtl/dpd_phase_ctl.sv
module dpd_phase_ctl
  import dpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ok,
  input  logic       req_lvl,
  input  logic       req_first,
  output store_act_e act,
  output logic       ph_q,
  output logic       sync_q
);
  logic ph_d, swal_q, swal_d, sync_d;

  // Next-state: divider phase, swallow flag, reset output
  always_comb begin
    ph_d   = ph_q;
    swal_d = swal_q;
    sync_d = 1'b0;
    act    = ACT_FREEZE;
    if (req_first) begin
      if (!ph_q) begin
        act    = ACT_LOAD;   // aligned: take pending sample, enter reset phase
        ph_d   = 1'b1;
        swal_d = 1'b0;
        sync_d = 1'b1;
      end else begin
        swal_d = 1'b1;       // misaligned: this edge is swallowed
      end
    end else if (req_lvl) begin
      sync_d = ~swal_q;
    end else if (ph_q) begin
      act  = ACT_EMIT;
      ph_d = 1'b0;
    end else begin
      act  = ACT_LOAD;
      ph_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      ph_q   <= 1'b0;
      swal_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      swal_q <= swal_d;
      sync_q <= sync_d;
    end
  end

  // R7: divider sits at reset-phase level after any edge with request active
  a_r7_drdy_reset_level: assert property (@(posedge clk) disable iff (!rst_ok)
    req_lvl |=> ph_q) else $error("drdy left reset phase during request");

  // R6: swallowed edge never raises the reset output
  a_r6_swallow_no_sync: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_first && ph_q) |=> !sync_q) else $error("sync_out after swallow");

  // R3: free-running divider toggles every edge
  a_r3_drdy_toggles: assert property (@(posedge clk) disable iff (!rst_ok)
    !req_lvl |=> (ph_q != $past(ph_q))) else $error("drdy did not toggle");

  // R5: reset output only follows an active request
  a_r5_sync_needs_req: assert property (@(posedge clk) disable iff (!rst_ok)
    sync_q |-> $past(req_lvl)) else $error("sync_out without request");
endmodule

// File: rtl/dpd_pair_store.sv
module dpd_pair_store
  import dpd_pkg::*;
#(
  parameter int SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst_ok,
  input  store_act_e          act,
  input  logic [SAMPLE_W-1:0] smp_in,
  output logic [SAMPLE_W-1:0] aux_q,
  output logic [SAMPLE_W-1:0] pri_q
);
  logic                hold_en, port_en;
  logic [SAMPLE_W-1:0] hold_q;

  assign hold_en = (act == ACT_LOAD);
  assign port_en = (act == ACT_EMIT);

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok)      hold_q <= '0;
    else if (hold_en) hold_q <= smp_in;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      aux_q <= '0;
      pri_q <= '0;
    end else if (port_en) begin
      aux_q <= hold_q;
      pri_q <= smp_in;
    end
  end

  // R2: ports never change on an edge that only loads the hold register
  a_r2_load_keeps_ports: assert property (@(posedge clk) disable iff (!rst_ok)
    (act == ACT_LOAD) |=> ($stable(aux_q) && $stable(pri_q)))
    else $error("ports changed on load edge");
endmodule

// File: rtl/dual_port_demux.sv
module dual_port_demux
  import dpd_pkg::*;
#(
  parameter int SAMPLE_W    = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] smp_in,
  input  logic                sync_req,
  output logic [SAMPLE_W-1:0] aux_out,
  output logic [SAMPLE_W-1:0] pri_out,
  output logic                drdy,
  output logic                sync_out
);
  logic       rst_ok, req_lvl, req_first;
  store_act_e act;

  dpd_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .rst_ok (rst_ok)
  );

  dpd_req_sync #(.STAGES(SYNC_STAGES)) u_req (
    .clk       (clk),
    .rst_ok    (rst_ok),
    .req_in    (sync_req),
    .req_lvl   (req_lvl),
    .req_first (req_first)
  );

  dpd_phase_ctl u_ctl (
    .clk       (clk),
    .rst_ok    (rst_ok),
    .req_lvl   (req_lvl),
    .req_first (req_first),
    .act       (act),
    .ph_q      (drdy),
    .sync_q    (sync_out)
  );

  dpd_pair_store #(.SAMPLE_W(SAMPLE_W)) u_store (
    .clk    (clk),
    .rst_ok (rst_ok),
    .act    (act),
    .smp_in (smp_in),
    .aux_q  (aux_out),
    .pri_q  (pri_out)
  );

  // R7: ports frozen on every edge that sees the synchronized request
  a_r7_ports_frozen: assert property (@(posedge clk) disable iff (!rst_ok)
    req_lvl |=> ($stable(aux_out) && $stable(pri_out)))
    else $error("ports moved during request");
endmodule

// File: tb/dual_port_demux_bench.sv
module dual_port_demux_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n, sync_req;
  logic [W-1:0] smp_in;
  logic [W-1:0] aux_out, pri_out;
  logic         drdy, sync_out;
  int           errors = 0;
  int           checks = 0;
  logic [W-1:0] held;

  always #5 clk = ~clk;

  dual_port_demux u_dual_port_demux (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .sync_req(sync_req),
    .aux_out(aux_out), .pri_out(pri_out), .drdy(drdy), .sync_out(sync_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive on falling edge, return at next falling edge
  task automatic cyc(input logic [W-1:0] d, input logic r);
    smp_in   = d;
    sync_req = r;
    @(negedge clk);
  endtask

  task automatic push(input logic [W-1:0] d);
    cyc(d, 1'b0);
    if (drdy) held = d;
  endtask

  task automatic t_reset();
    rst_n = 1'b1; sync_req = 1'b0; smp_in = '0; held = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 aux", aux_out, 0);
    chk("R1 pri", pri_out, 0);
    chk("R1 drdy", drdy, 0);
    chk("R1 sync", sync_out, 0);
    rst_n = 1'b1;
    smp_in = 8'hEE;
    repeat (2) @(negedge clk);
    chk("R1 idle during release", drdy, 0);
  endtask

  task automatic t_stream();
    push(8'h10);
    chk("R3 drdy after first", drdy, 1);
    chk("R2 aux unchanged on load", aux_out, 0);
    push(8'h11);
    chk("R2 aux older", aux_out, 8'h10);
    chk("R2 pri newer", pri_out, 8'h11);
    chk("R3 drdy after pair", drdy, 0);
    push(8'h12);
    chk("R2 pri unchanged on load", pri_out, 8'h11);
    push(8'h13);
    chk("R2 aux second pair", aux_out, 8'h12);
    chk("R2 pri second pair", pri_out, 8'h13);
  endtask

  task automatic t_sync(input int len, input bit aligned, input logic [W-1:0] base);
    logic [W-1:0] h0, fa, fp;
    string sync_tag;
    if ((drdy == 1'b0) != aligned) push(base ^ 8'hF0);
    h0 = held;
    fa = aligned ? W'(base + 1) : h0;
    fp = aligned ? W'(base + 2) : W'(base + 1);
    sync_tag = (len == 1) ? "R9 sync" : (aligned ? "R5 sync" : "R6 sync");
    for (int j = 1; j <= len + 3; j++) begin
      cyc(W'(base + j), (j <= len));
      chk(sync_tag, sync_out, (aligned && j >= 3 && j <= len + 2) ? 1 : 0);
      if (j == 2)
        chk("R4 still running", drdy, aligned ? 0 : 1);
      if (j >= 3 && j <= len + 2) begin
        chk("R7 drdy held", drdy, 1);
        chk("R7 aux frozen", aux_out, fa);
        chk("R7 pri frozen", pri_out, fp);
      end
      if (j == len + 3) begin
        chk("R8 aux held sample", aux_out, aligned ? W'(base + 3) : W'(base + 2));
        chk("R8 pri first new", pri_out, W'(base + j));
        chk("R8 drdy low", drdy, 0);
      end
    end
    push(W'(base + 8'h40));
    push(W'(base + 8'h41));
    chk("R2 pairs resume", pri_out, W'(base + 8'h41));
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_stream();
    t_sync(2, 1'b1, 8'h20);   // R5 nominal aligned
    t_sync(2, 1'b0, 8'h60);   // R6 swallowed
    t_sync(1, 1'b1, 8'h80);   // R9 single-cycle aligned
    t_sync(1, 1'b0, 8'hA0);   // R6 single-cycle swallowed
    t_sync(5, 1'b1, 8'hC0);   // R5 long request
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule